// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block gathers sixteen interrupt request lines into two 8-input controllers. The primary controller takes lines 0 to 7 directly. The secondary controller takes lines 8 to 15 and feeds the primary through primary input 2, the cascade input. Each controller keeps a request register and an in-service register.

A per-line edge/level configuration decides whether a de-asserted line withdraws its request. A combinational `pending` output tells the processor side that an unmasked request is waiting. A one-cycle `ack` strobe then grants one request under a rotating priority scheme. Masks, vector bases, lowest-priority pointers and in-service clear pulses all arrive from a separate command unit as plain inputs.

Grant order is fixed. The primary is searched first, and its cascade input is skipped during that search. Only when the primary has nothing grantable is the secondary searched. The granted vector, or an all-ones "nothing granted" code, is registered and appears on the cycle after the strobe.

Top module: `irq_cascade_resolver`

## Requirements
- R1: An `irq_set` pulse on line n (0..7) sets primary request bit n. A pulse on line n (8..15) sets secondary request bit n-8 and also sets primary request bit 2. All of these take effect at the next clock edge.
- R2: An `irq_clr` pulse on line n clears that line's request bit at the next edge only when `level_cfg[n]` is 1 (level mode). When `level_cfg[n]` is 0 (edge mode), the request bit keeps its value.
- R3: A level-mode clear on a secondary line that leaves the secondary request register at zero also clears primary request bit 2 in the same edge.
- R4: `pending` is 1 exactly when at least one of two sets is non-empty: the primary requests outside `pri_mask` other than bit 2, or the secondary requests outside `sec_mask`.
- R5: On `ack`, the primary is scanned starting at index (`pri_low`+1) mod 8 and wrapping through all eight indices. Index 2 and masked indices are skipped, and the first eligible index wins.
- R6: A primary grant clears that request bit and sets the matching in-service bit. One cycle after `ack`, `ack_done` is 1 and `ack_vec` is {8'h00, (`pri_base` + index) mod 256}.
- R7: If the primary has no eligible index, the secondary is scanned the same way starting at (`sec_low`+1) mod 8. A secondary grant clears the secondary request bit and primary request bit 2. It sets the secondary in-service bit and primary in-service bit 2. The next cycle, `ack_vec` = {8'h00, (`sec_base` + index) mod 256}.
- R8: An `ack` with nothing eligible in either controller changes no register bit. The next cycle, `ack_vec` = 16'hFFFF with `ack_done` = 1.
- R9: `pri_isr_clr` and `sec_isr_clr` clear in-service bits at the next edge. When a grant sets the same bit in the same cycle, the bit ends up set.
- R10: After reset, all request and in-service bits are 0, `ack_done` is 0 and `ack_vec` is 16'h0000. When `ack` is 0, `ack_done` is 0 and `ack_vec` holds its last value.
- R11: When a new `irq_set` pulse and a level clear or a grant hit the same request bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_set | input | 16 | Per-line request assertion pulses |
| irq_clr | input | 16 | Per-line request de-assertion pulses |
| level_cfg | input | 16 | Per-line trigger mode, 1 = level, 0 = edge |
| pri_mask | input | 8 | Primary mask, 1 = masked |
| sec_mask | input | 8 | Secondary mask, 1 = masked |
| pri_base | input | 8 | Primary vector base |
| sec_base | input | 8 | Secondary vector base |
| pri_low | input | 3 | Primary lowest-priority index |
| sec_low | input | 3 | Secondary lowest-priority index |
| pri_isr_clr | input | 8 | Primary in-service clear pulses |
| sec_isr_clr | input | 8 | Secondary in-service clear pulses |
| ack | input | 1 | Acknowledge strobe, one cycle |
| pending | output | 1 | Unmasked request waiting |
| ack_done | output | 1 | Acknowledge result valid this cycle |
| ack_vec | output | 16 | Granted vector, or 16'hFFFF when nothing was granted |
| pri_irr | output | 8 | Primary request register |
| sec_irr | output | 8 | Secondary request register |
| pri_isr | output | 8 | Primary in-service register |
| sec_isr | output | 8 | Secondary in-service register |

## Verification
The assertions treat `ack` as a strobe that is sampled at each rising edge. They take the masks, bases and pointers as the values present at that same edge, so a command unit may change them on any cycle.

The edge-mode hold property applies only to cycles with no level-mode clear and no `ack`. Only those cycles have no legal way to drop a primary request bit.

The bench draws sparse set and clear pulses and fresh configuration words from a seeded `$urandom`. It changes the configuration only between bursts. It then adds directed cycles for the cascade drop, the empty acknowledge and the same-cycle set/clear conflicts, so that every rule is reached.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int CTRL_N      = 8;
  localparam int IDX_W       = $clog2(CTRL_N);
  localparam int LINES       = 2 * CTRL_N;
  localparam int VEC_W       = 8;
  localparam int OUT_W       = 16;
  localparam int CASCADE_IDX = 2;
  localparam logic [OUT_W-1:0] NO_GRANT = {OUT_W{1'b1}};

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } scan_res_t;
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] low_ptr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  localparam logic [IW:0] N_EXT = (IW+1)'(N);

  logic [IW-1:0] start;
  logic [IW-1:0] pos [N];
  logic [N-1:0]  rot;

  // first searched position sits just above the lowest-priority index
  assign start = (low_ptr == IW'(N-1)) ? '0 : low_ptr + 1'b1;

  generate
    for (genvar k = 0; k < N; k++) begin : g_rot
      logic [IW:0] sum;
      assign sum    = {1'b0, start} + (IW+1)'(k);
      assign pos[k] = (sum >= N_EXT) ? IW'(sum - N_EXT) : sum[IW-1:0];
      assign rot[k] = req[pos[k]];
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = N-1; k >= 0; k--) begin
      if (rot[k]) begin
        hit = 1'b1;
        idx = pos[k];
      end
    end
  end

  always_comb begin
    onehot = '0;
    if (hit) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_set,
  input  logic [N-1:0] req_drop,
  input  logic [N-1:0] grant,
  input  logic [N-1:0] isr_clr,
  output logic [N-1:0] irr_q,
  output logic [N-1:0] irr_d,
  output logic [N-1:0] isr_q
);
  logic [N-1:0] isr_d;

  // new assertion wins over drop and grant on the same bit
  always_comb begin
    irr_d = (irr_q & ~grant & ~req_drop) | req_set;
    isr_d = (isr_q & ~isr_clr) | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
    end
  end
endmodule

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver
  import irq_res_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINES-1:0]    irq_set,
  input  logic [LINES-1:0]    irq_clr,
  input  logic [LINES-1:0]    level_cfg,
  input  logic [CTRL_N-1:0]   pri_mask,
  input  logic [CTRL_N-1:0]   sec_mask,
  input  logic [VEC_W-1:0]    pri_base,
  input  logic [VEC_W-1:0]    sec_base,
  input  logic [IDX_W-1:0]    pri_low,
  input  logic [IDX_W-1:0]    sec_low,
  input  logic [CTRL_N-1:0]   pri_isr_clr,
  input  logic [CTRL_N-1:0]   sec_isr_clr,
  input  logic                ack,
  output logic                pending,
  output logic                ack_done,
  output logic [OUT_W-1:0]    ack_vec,
  output logic [CTRL_N-1:0]   pri_irr,
  output logic [CTRL_N-1:0]   sec_irr,
  output logic [CTRL_N-1:0]   pri_isr,
  output logic [CTRL_N-1:0]   sec_isr
);
  localparam logic [CTRL_N-1:0] CASC_BIT = CTRL_N'(1) << CASCADE_IDX;

  logic [LINES-1:0]  lvl_drop;
  logic [CTRL_N-1:0] pri_eligible, sec_eligible;
  logic [CTRL_N-1:0] pri_oh, sec_oh;
  logic [CTRL_N-1:0] pri_grant, sec_grant;
  logic [CTRL_N-1:0] pri_set, pri_drop;
  logic [CTRL_N-1:0] pri_irr_d, sec_irr_d;
  scan_res_t         pri_res, sec_res;
  logic              sec_take, casc_drop;
  logic              ack_done_d;
  logic [OUT_W-1:0]  ack_vec_d;

  // trigger mode gating of de-assertions
  assign lvl_drop = irq_clr & level_cfg;

  // eligibility and pending
  always_comb begin
    pri_eligible = pri_irr & ~(pri_mask | CASC_BIT);
    sec_eligible = sec_irr & ~sec_mask;
    pending      = (|pri_eligible) | (|sec_eligible);
  end

  irq_prio_scan #(.N(CTRL_N)) u_pri_scan (
    .req(pri_eligible), .low_ptr(pri_low),
    .hit(pri_res.hit), .idx(pri_res.idx), .onehot(pri_oh)
  );

  irq_prio_scan #(.N(CTRL_N)) u_sec_scan (
    .req(sec_eligible), .low_ptr(sec_low),
    .hit(sec_res.hit), .idx(sec_res.idx), .onehot(sec_oh)
  );

  // grant selection: primary first, secondary only when primary is empty
  always_comb begin
    sec_take  = ack && !pri_res.hit && sec_res.hit;
    sec_grant = sec_take ? sec_oh : '0;
    pri_grant = '0;
    if (ack && pri_res.hit) pri_grant = pri_oh;
    else if (sec_take)      pri_grant = CASC_BIT;
  end

  // cascade request maintenance
  always_comb begin
    casc_drop = (|lvl_drop[LINES-1:CTRL_N]) && (sec_irr_d == '0);
    pri_set   = irq_set[CTRL_N-1:0];
    if (|irq_set[LINES-1:CTRL_N]) pri_set = pri_set | CASC_BIT;
    pri_drop  = lvl_drop[CTRL_N-1:0];
    if (casc_drop) pri_drop = pri_drop | CASC_BIT;
  end

  irq_ctrl_bank #(.N(CTRL_N)) u_sec_bank (
    .clk(clk), .rst_n(rst_n),
    .req_set(irq_set[LINES-1:CTRL_N]), .req_drop(lvl_drop[LINES-1:CTRL_N]),
    .grant(sec_grant), .isr_clr(sec_isr_clr),
    .irr_q(sec_irr), .irr_d(sec_irr_d), .isr_q(sec_isr)
  );

  irq_ctrl_bank #(.N(CTRL_N)) u_pri_bank (
    .clk(clk), .rst_n(rst_n),
    .req_set(pri_set), .req_drop(pri_drop),
    .grant(pri_grant), .isr_clr(pri_isr_clr),
    .irr_q(pri_irr), .irr_d(pri_irr_d), .isr_q(pri_isr)
  );

  // acknowledge result, next state
  always_comb begin
    ack_done_d = ack;
    ack_vec_d  = NO_GRANT;
    if (pri_res.hit)
      ack_vec_d = OUT_W'(pri_base + VEC_W'(pri_res.idx));
    else if (sec_res.hit)
      ack_vec_d = OUT_W'(sec_base + VEC_W'(sec_res.idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_done <= 1'b0;
      ack_vec  <= '0;
    end else begin
      ack_done <= ack_done_d;
      if (ack) ack_vec <= ack_vec_d;
    end
  end

  // ---------------- assertions ----------------
  assert_cascade_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set[LINES-1:CTRL_N]) |-> pri_irr_d[CASCADE_IDX]);

  assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && lvl_drop == '0) |=> (($past(pri_irr) & ~pri_irr) == '0));

  assert_cascade_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && (|lvl_drop[LINES-1:CTRL_N]) && irq_set == '0 && sec_irr_d == '0)
    |=> !pri_irr[CASCADE_IDX]);

  assert_primary_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pri_res.hit) |=> (ack_done && ack_vec[OUT_W-1:VEC_W] == '0 &&
      pri_isr[$past(pri_res.idx)] &&
      ack_vec[VEC_W-1:0] == $past(pri_base) + VEC_W'($past(pri_res.idx))));

  assert_secondary_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_take |=> (pri_isr[CASCADE_IDX] && sec_isr[$past(sec_res.idx)]));

  assert_empty_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pending) |=> (ack_done && ack_vec == NO_GRANT));

  assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (!ack_done && $stable(ack_vec)));

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pri_grant) && $onehot0(sec_grant));
endmodule

// File: tb/sim_irq_cascade_resolver.sv
module sim_irq_cascade_resolver;
  logic        clk, rst_n;
  logic [15:0] irq_set, irq_clr, level_cfg;
  logic [7:0]  pri_mask, sec_mask, pri_base, sec_base, pri_isr_clr, sec_isr_clr;
  logic [2:0]  pri_low, sec_low;
  logic        ack;
  logic        pending, ack_done;
  logic [15:0] ack_vec;
  logic [7:0]  pri_irr, sec_irr, pri_isr, sec_isr;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [7:0]  m_pirr, m_sirr, m_pisr, m_sisr;
  logic        m_done;
  logic [15:0] m_vec;

  irq_cascade_resolver u0 (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .irq_clr(irq_clr),
    .level_cfg(level_cfg), .pri_mask(pri_mask), .sec_mask(sec_mask),
    .pri_base(pri_base), .sec_base(sec_base), .pri_low(pri_low), .sec_low(sec_low),
    .pri_isr_clr(pri_isr_clr), .sec_isr_clr(sec_isr_clr), .ack(ack),
    .pending(pending), .ack_done(ack_done), .ack_vec(ack_vec),
    .pri_irr(pri_irr), .sec_irr(sec_irr), .pri_isr(pri_isr), .sec_isr(sec_isr)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int scan(logic [7:0] req, logic [2:0] low);
    for (int k = 1; k <= 8; k++) begin
      int p = (int'(low) + k) % 8;
      if (req[p]) return p;
    end
    return -1;
  endfunction

  function automatic logic exp_pending();
    return ((m_pirr & ~(pri_mask | 8'h04)) != 0) || ((m_sirr & ~sec_mask) != 0);
  endfunction

  task automatic check_all();
    chk("R1 pri_irr", {8'h0, pri_irr}, {8'h0, m_pirr});
    chk("R2 sec_irr", {8'h0, sec_irr}, {8'h0, m_sirr});
    chk("R6 pri_isr", {8'h0, pri_isr}, {8'h0, m_pisr});
    chk("R7 sec_isr", {8'h0, sec_isr}, {8'h0, m_sisr});
    chk("R4 pending", {15'h0, pending}, {15'h0, exp_pending()});
    chk("R10 ack_done", {15'h0, ack_done}, {15'h0, m_done});
    chk("R5 ack_vec", ack_vec, m_vec);
  endtask

  // one clock: drive, predict, step, compare
  task automatic cyc(logic [15:0] s, logic [15:0] c, logic a, logic [7:0] pc, logic [7:0] sc);
    logic [15:0] lvl;
    logic [7:0]  pg, sg, sn;
    int pi, si;
    irq_set = s; irq_clr = c; ack = a; pri_isr_clr = pc; sec_isr_clr = sc;
    lvl = c & level_cfg;
    pg = 0; sg = 0;
    pi = scan(m_pirr & ~(pri_mask | 8'h04), pri_low);
    si = scan(m_sirr & ~sec_mask, sec_low);
    if (a) begin
      if (pi >= 0) pg[pi] = 1'b1;
      else if (si >= 0) begin sg[si] = 1'b1; pg[2] = 1'b1; end
    end
    sn = (m_sirr & ~sg & ~lvl[15:8]) | s[15:8];
    @(posedge clk);
    m_pirr = (m_pirr & ~pg & ~lvl[7:0] & ~(((lvl[15:8] != 0) && sn == 0) ? 8'h04 : 8'h00))
             | s[7:0] | ((s[15:8] != 0) ? 8'h04 : 8'h00);
    m_sirr = sn;
    m_pisr = (m_pisr & ~pc) | pg;
    m_sisr = (m_sisr & ~sc) | sg;
    m_done = a;
    if (a) m_vec = (pi >= 0) ? {8'h0, pri_base + 8'(pi)} :
                   (si >= 0) ? {8'h0, sec_base + 8'(si)} : 16'hFFFF;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; irq_set = 0; irq_clr = 0; level_cfg = 0; ack = 0;
    pri_mask = 0; sec_mask = 0; pri_base = 8'h20; sec_base = 8'h28;
    pri_low = 3'd7; sec_low = 3'd7; pri_isr_clr = 0; sec_isr_clr = 0;
    m_pirr = 0; m_sirr = 0; m_pisr = 0; m_sisr = 0; m_done = 0; m_vec = 0;
    repeat (3) @(negedge clk);
    check_all(); // R10 reset state
    rst_n = 1;
    @(negedge clk);

    // R3: level secondary line 9 raised then withdrawn drops the cascade bit
    level_cfg = 16'h0200;
    cyc(16'h0200, 0, 0, 0, 0);
    chk("R1 cascade bit set", {8'h0, pri_irr}, 16'h0004);
    cyc(0, 16'h0200, 0, 0, 0);
    chk("R3 cascade bit cleared", {8'h0, pri_irr}, 16'h0000);

    // R2: edge line 3 ignores de-assertion
    level_cfg = 0;
    cyc(16'h0008, 0, 0, 0, 0);
    cyc(0, 16'h0008, 0, 0, 0);
    chk("R2 edge request kept", {8'h0, pri_irr}, 16'h0008);

    // R5: rotation start at low+1, lines 1 and 5 pending plus cascade from 12
    pri_low = 3'd4;
    cyc(16'h1022, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R5 rotated winner", ack_vec, 16'h0025);
    cyc(0, 0, 1, 0, 0); // grants 1
    cyc(0, 0, 1, 0, 0); // grants 3
    chk("R6 primary vector", ack_vec, 16'h0023);
    cyc(0, 0, 1, 0, 0); // secondary 4
    chk("R7 secondary vector", ack_vec, 16'h002C);
    cyc(0, 0, 1, 0, 0);
    chk("R8 empty ack", ack_vec, 16'hFFFF);

    // R9: grant and in-service clear on the same bit: set wins
    cyc(16'h0001, 0, 0, 0, 0);
    cyc(0, 0, 1, 8'h01, 0);
    chk("R9 set beats clear", {8'h0, pri_isr}, {8'h0, m_pisr});
    cyc(0, 0, 0, 8'hFF, 8'hFF);
    chk("R9 clear", {8'h0, pri_isr}, 16'h0000);

    // R11: new set on the bit being granted keeps it requested
    cyc(16'h0040, 0, 0, 0, 0);
    cyc(16'h0040, 0, 1, 0, 0);
    chk("R11 set beats grant", {8'h0, pri_irr}, 16'h0040);

    // random bursts
    for (int b = 0; b < 40; b++) begin
      level_cfg = 16'($urandom); pri_mask = 8'($urandom) & 8'($urandom);
      sec_mask = 8'($urandom) & 8'($urandom);
      pri_base = 8'($urandom); sec_base = 8'($urandom);
      pri_low = 3'($urandom); sec_low = 3'($urandom);
      for (int t = 0; t < 30; t++) begin
        logic [15:0] s, c;
        s = 16'($urandom) & 16'($urandom) & 16'($urandom);
        c = 16'($urandom) & 16'($urandom);
        cyc(s, c, ($urandom % 3) == 0, 8'($urandom) & 8'($urandom),
            8'($urandom) & 8'($urandom));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule